// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Control

This block is the hazard controller of a five-stage in-order integer pipeline. Every instruction reads its source registers in the second stage and writes its destination in the fifth. Because of that, only read-after-write dependences can cause wrong results, and the block handles exactly those. The block is purely combinational. Each cycle it compares the two source register numbers of the instruction in execute with the destinations held in the two downstream pipeline registers: the execute/memory register and the memory/writeback register. From this comparison it drives the select lines of the two ALU operand multiplexers. The result is that a value computed in execute reaches the instructions right behind it without waiting for writeback.

A loaded value is not available until the end of the memory stage. It therefore cannot be bypassed to an instruction that is in execute in the very next cycle. To cover this case, the block compares the decode-stage source numbers with the destination of a load that is sitting in execute. On a match it freezes the program counter and the fetch/decode register, and tells the decode/execute register to take a bubble by clearing its control write-enables. This costs exactly one cycle. After that cycle the load has moved to the memory/writeback register, and the normal bypass path supplies its value. Register zero reads as the constant 0, so the block never forwards it and never stalls on it.

Top module: `hz_ctrl`

## Requirements
- R1: When no enabled downstream destination matches a source, that operand's select is 2'b00 (register file). The value 2'b11 never appears on a select.
- R2: When the execute/memory stage has its write enable set and its destination equals a non-zero source, that operand's select is 2'b10.
- R3: When only the memory/writeback stage has its write enable set with a destination equal to a non-zero source, that operand's select is 2'b01.
- R4: When both downstream stages match the same source, the younger result wins and the select is 2'b10.
- R5: A stage whose write enable is low never causes a forward, even when its destination number matches.
- R6: A source or destination of register 0 never produces a forward. A source of 0 always selects 2'b00.
- R7: The stall outputs (pc_hold, ifid_hold, idex_bubble) are all 1 when the execute-stage instruction is a load whose non-zero destination equals either decode-stage source.
- R8: The three stall outputs are always equal. They are 0 when the execute-stage instruction is not a load, or when its destination matches neither decode source.
- R9: A load whose destination is register 0 never stalls the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1 | input | 5 | First source register of the instruction in execute |
| ex_rs2 | input | 5 | Second source register of the instruction in execute |
| id_rs1 | input | 5 | First source register of the instruction in decode |
| id_rs2 | input | 5 | Second source register of the instruction in decode |
| idex_memrd | input | 1 | Instruction in execute is a load |
| idex_rd | input | 5 | Destination register of the instruction in execute |
| exmem_we | input | 1 | Register write enable held in execute/memory register |
| exmem_rd | input | 5 | Destination held in execute/memory register |
| memwb_we | input | 1 | Register write enable held in memory/writeback register |
| memwb_rd | input | 5 | Destination held in memory/writeback register |
| fwd_a | output | 2 | Select for ALU operand A multiplexer |
| fwd_b | output | 2 | Select for ALU operand B multiplexer |
| pc_hold | output | 1 | Freeze program counter |
| ifid_hold | output | 1 | Freeze fetch/decode register |
| idex_bubble | output | 1 | Clear control enables entering execute |

## Verification
The checker tests, whenever the inputs are known, the following properties. The select code is never 2'b11. A zero source always reads the register file. A matching enabled execute/memory destination always takes priority. The three stall lines always agree. No stall occurs without a load in execute or with a load into register 0. Whether the memory/writeback path is chosen only when the newer stage is silent, and whether a stall is raised for exactly the right decode sources, is shown by the bench's scenarios: dependent ALU chains, disabled writers, a load-use pair on each source, and a load followed by an unrelated instruction.

// File: rtl/hz_pkg.sv
package hz_pkg;
   typedef enum logic [1:0] {
      SEL_REGFILE = 2'b00,
      SEL_WBACK   = 2'b01,
      SEL_EXMEM   = 2'b10
   } opnd_sel_e;
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
   parameter int REG_AW    = 5,
   parameter bit ZERO_HARD = 1'b1
) (
   input  logic [REG_AW-1:0] src,
   input  logic [REG_AW-1:0] dst,
   input  logic              dst_we,
   output logic              hit
);
   logic same;
   assign same = (src == dst) && dst_we;
   generate
      if (ZERO_HARD) begin : g_zero_guard
         assign hit = same && (dst != '0);
      end else begin : g_no_guard
         assign hit = same;
      end
   endgenerate
endmodule

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
   import hz_pkg::*;
#(
   parameter int REG_AW    = 5,
   parameter int NUM_SRC   = 2,
   parameter bit ZERO_HARD = 1'b1
) (
   input  logic [NUM_SRC-1:0][REG_AW-1:0] srcs,
   input  logic                           exmem_we,
   input  logic [REG_AW-1:0]              exmem_rd,
   input  logic                           memwb_we,
   input  logic [REG_AW-1:0]              memwb_rd,
   output opnd_sel_e [NUM_SRC-1:0]        sel
);
   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      logic near_hit, far_hit;
      hz_src_match #(.REG_AW(REG_AW), .ZERO_HARD(ZERO_HARD)) u_near (
         .src(srcs[s]), .dst(exmem_rd), .dst_we(exmem_we), .hit(near_hit));
      hz_src_match #(.REG_AW(REG_AW), .ZERO_HARD(ZERO_HARD)) u_far (
         .src(srcs[s]), .dst(memwb_rd), .dst_we(memwb_we), .hit(far_hit));
      always_comb begin
         if (near_hit)     sel[s] = SEL_EXMEM;
         else if (far_hit) sel[s] = SEL_WBACK;
         else              sel[s] = SEL_REGFILE;
      end
   end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
   parameter int REG_AW    = 5,
   parameter int NUM_SRC   = 2,
   parameter bit ZERO_HARD = 1'b1
) (
   input  logic [NUM_SRC-1:0][REG_AW-1:0] id_srcs,
   input  logic                           ld_valid,
   input  logic [REG_AW-1:0]              ld_rd,
   output logic                           stall
);
   logic [NUM_SRC-1:0] dep;
   for (genvar s = 0; s < NUM_SRC; s++) begin : g_dep
      hz_src_match #(.REG_AW(REG_AW), .ZERO_HARD(ZERO_HARD)) u_cmp (
         .src(id_srcs[s]), .dst(ld_rd), .dst_we(ld_valid), .hit(dep[s]));
   end
   assign stall = |dep;
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
   import hz_pkg::*;
#(
   parameter int REG_AW    = 5,
   parameter bit ZERO_HARD = 1'b1
) (
   input  logic [REG_AW-1:0] ex_rs1,
   input  logic [REG_AW-1:0] ex_rs2,
   input  logic [REG_AW-1:0] id_rs1,
   input  logic [REG_AW-1:0] id_rs2,
   input  logic              idex_memrd,
   input  logic [REG_AW-1:0] idex_rd,
   input  logic              exmem_we,
   input  logic [REG_AW-1:0] exmem_rd,
   input  logic              memwb_we,
   input  logic [REG_AW-1:0] memwb_rd,
   output logic [1:0]        fwd_a,
   output logic [1:0]        fwd_b,
   output logic              pc_hold,
   output logic              ifid_hold,
   output logic              idex_bubble
);
   localparam int NUM_SRC = 2;

   if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
      $error("hz_ctrl: REG_AW out of range");
   end

   logic [NUM_SRC-1:0][REG_AW-1:0] ex_srcs, id_srcs;
   opnd_sel_e [NUM_SRC-1:0]        sel;
   logic                           stall;

   assign ex_srcs = {ex_rs2, ex_rs1};
   assign id_srcs = {id_rs2, id_rs1};

   hz_fwd_unit #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC), .ZERO_HARD(ZERO_HARD)) u_fwd (
      .srcs(ex_srcs), .exmem_we(exmem_we), .exmem_rd(exmem_rd),
      .memwb_we(memwb_we), .memwb_rd(memwb_rd), .sel(sel));

   hz_load_use #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC), .ZERO_HARD(ZERO_HARD)) u_lu (
      .id_srcs(id_srcs), .ld_valid(idex_memrd), .ld_rd(idex_rd), .stall(stall));

   assign fwd_a       = sel[0];
   assign fwd_b       = sel[1];
   assign pc_hold     = stall;
   assign ifid_hold   = stall;
   assign idex_bubble = stall;
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk #(
   parameter int REG_AW = 5
) (
   input logic [REG_AW-1:0] ex_rs1,
   input logic [REG_AW-1:0] ex_rs2,
   input logic [REG_AW-1:0] id_rs1,
   input logic [REG_AW-1:0] id_rs2,
   input logic              idex_memrd,
   input logic [REG_AW-1:0] idex_rd,
   input logic              exmem_we,
   input logic [REG_AW-1:0] exmem_rd,
   input logic              memwb_we,
   input logic [REG_AW-1:0] memwb_rd,
   input logic [1:0]        fwd_a,
   input logic [1:0]        fwd_b,
   input logic              pc_hold,
   input logic              ifid_hold,
   input logic              idex_bubble
);
   logic known;
   assign known = !$isunknown({ex_rs1, ex_rs2, id_rs1, id_rs2, idex_memrd,
                               idex_rd, exmem_we, exmem_rd, memwb_we, memwb_rd});
   always_comb begin
      if (known) begin
         p_sel_legal_r1: assert (fwd_a != 2'b11 && fwd_b != 2'b11);
         p_zero_src_r6: assert ((ex_rs1 != '0 || fwd_a == 2'b00) &&
                                (ex_rs2 != '0 || fwd_b == 2'b00));
         p_near_wins_r4: assert (!(exmem_we && exmem_rd != '0 && exmem_rd == ex_rs1)
                                 || fwd_a == 2'b10);
         p_stall_agree_r8: assert (pc_hold == ifid_hold && ifid_hold == idex_bubble);
         p_no_load_r8: assert (idex_memrd || !idex_bubble);
         p_zero_load_r9: assert (idex_rd != '0 || !pc_hold);
      end
   end
endmodule

bind hz_ctrl hz_ctrl_chk #(.REG_AW(REG_AW)) u_chk (.*);

// File: tb/hz_ctrl_bench.sv
module hz_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 8;

   typedef struct packed {
      logic [4:0] rs1, rs2, mrd, wrd;
      logic       mwe, wwe;
      logic [1:0] ea, eb;
   } vec_t;

   localparam vec_t VECS [NV] = '{
      '{5'd1, 5'd2, 5'd3, 5'd4, 1'b1, 1'b1, 2'b00, 2'b00}, // R1
      '{5'd3, 5'd2, 5'd3, 5'd4, 1'b1, 1'b1, 2'b10, 2'b00}, // R2
      '{5'd5, 5'd4, 5'd3, 5'd4, 1'b1, 1'b1, 2'b00, 2'b01}, // R3
      '{5'd7, 5'd7, 5'd7, 5'd7, 1'b1, 1'b1, 2'b10, 2'b10}, // R4
      '{5'd7, 5'd7, 5'd7, 5'd7, 1'b0, 1'b1, 2'b01, 2'b01}, // R5
      '{5'd7, 5'd7, 5'd7, 5'd7, 1'b0, 1'b0, 2'b00, 2'b00}, // R5
      '{5'd0, 5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 2'b00, 2'b00}, // R6
      '{5'd0, 5'd9, 5'd0, 5'd9, 1'b1, 1'b1, 2'b00, 2'b01}  // R6
   };

   logic clk = 1'b0;
   logic [4:0] ex_rs1, ex_rs2, id_rs1, id_rs2, idex_rd, exmem_rd, memwb_rd;
   logic idex_memrd, exmem_we, memwb_we;
   logic [1:0] fwd_a, fwd_b;
   logic pc_hold, ifid_hold, idex_bubble;
   int checks = 0, errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hz_ctrl u_hz_ctrl (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic load_case(input string req, input logic ld, input logic [4:0] rd,
                            input logic [4:0] s1, input logic [4:0] s2, input logic exp);
      @(negedge clk);
      idex_memrd = ld; idex_rd = rd; id_rs1 = s1; id_rs2 = s2;
      #1;
      check(req, {pc_hold, ifid_hold, idex_bubble}, {3{exp}});
   endtask

   initial begin
      ex_rs1 = '0; ex_rs2 = '0; id_rs1 = '0; id_rs2 = '0; idex_rd = '0;
      exmem_rd = '0; memwb_rd = '0; idex_memrd = 1'b0; exmem_we = 1'b0; memwb_we = 1'b0;
      @(negedge clk); #1;
      check("R1 idle", {fwd_a, fwd_b}, 4'b0000);
      check("R8 idle", {pc_hold, ifid_hold, idex_bubble}, 3'b000);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         ex_rs1 = VECS[i].rs1; ex_rs2 = VECS[i].rs2;
         exmem_rd = VECS[i].mrd; memwb_rd = VECS[i].wrd;
         exmem_we = VECS[i].mwe; memwb_we = VECS[i].wwe;
         #1;
         check($sformatf("R1-table vec %0d fwd_a", i), fwd_a, VECS[i].ea);
         check($sformatf("R1-table vec %0d fwd_b", i), fwd_b, VECS[i].eb);
      end

      // Forwarding must not disturb the interlock: no load in execute
      check("R8 forwarding without load", pc_hold, 1'b0);

      load_case("R7 load-use on rs1", 1'b1, 5'd5, 5'd5, 5'd6, 1'b1);
      load_case("R7 load-use on rs2", 1'b1, 5'd5, 5'd2, 5'd5, 1'b1);
      load_case("R8 load then unrelated", 1'b1, 5'd5, 5'd6, 5'd7, 1'b0);
      load_case("R8 ALU producer not a load", 1'b0, 5'd5, 5'd5, 5'd5, 1'b0);
      load_case("R9 load into zero", 1'b1, 5'd0, 5'd0, 5'd0, 1'b0);

      // After the bubble the load sits in MEM/WB: bypass from there
      @(negedge clk);
      idex_memrd = 1'b0; ex_rs1 = 5'd5; ex_rs2 = 5'd1;
      exmem_we = 1'b0; exmem_rd = 5'd0; memwb_we = 1'b1; memwb_rd = 5'd5;
      #1;
      check("R3 load value after bubble", fwd_a, 2'b01);
      check("R1 other operand", fwd_b, 2'b00);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (2000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule